// File: doc/BRIEF.md
# Load/Store Pipeline Stall Controller

This block steers instruction descriptors through a four-slot in-order integer pipeline: fetch, decode with address generation, a shared execute/memory slot, and writeback. Descriptors arrive one per cycle over a valid/ready stream. Each descriptor carries an operation class (ALU or memory), a dependency flag and a tag. The block reports which slots are occupied, raises a stall indication and presents the retiring descriptor at writeback.

Two memory operations may overlap. While one sits in the memory slot, the next computes its address in decode. An ALU operation that consumes the result of the load just ahead of it proceeds without a bubble. When the bus interface signals a wait state for a memory operation in the memory slot, that operation stays where it is. Fetch and decode freeze behind it, and writeback receives an empty slot. The input stream applies back-pressure by dropping `in_ready` for exactly the stalled cycles.

Stream rules: a descriptor transfers on a rising edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, the source keeps `in_valid` and the descriptor fields unchanged. A cycle with `in_valid` low enters fetch as an empty slot.

Top module: `lsp_pipe_ctrl`

## Requirements
- R1: A synchronous reset empties every slot (`slot_valid` = 0) and drives `stall` low.
- R2: With no stall, a descriptor accepted on one edge occupies fetch, decode, memory and writeback in the four following cycles, in that order. The `slot_valid` bit positions are 0 for fetch, 1 for decode, 2 for memory and 3 for writeback.
- R3: Memory operations with no wait state overlap. Two consecutive ones occupy decode and memory in the same cycle and retire on consecutive cycles.
- R4: An ALU operation with `in_dep` = 1 directly behind a load creates no stall and retires the cycle after that load.
- R5: `stall` is high exactly while the memory slot holds a valid memory operation (`in_op` = 1) and `bus_ready` is low. During a stall, fetch, decode and memory keep their contents.
- R6: Each wait-state cycle delays retirement by exactly one cycle and puts an empty slot into writeback. The held memory operation moves on at the edge where `bus_ready` is high, and the operation behind it enters memory at that same edge.
- R7: `bus_ready` has no effect while the memory slot is empty or holds an ALU operation (`in_op` = 0).
- R8: `in_ready` is the inverse of `stall`. A descriptor offered while `in_ready` is low is taken only once `in_ready` returns high.
- R9: At writeback, `wb_tag`, `wb_mem` and `wb_dep` repeat the tag, class and dependency flag of the retiring descriptor, and they are meaningful while `slot_valid[3]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor can be taken this cycle |
| in_op | input | 1 | 1 = memory operation, 0 = ALU operation |
| in_dep | input | 1 | Operation consumes the previous result |
| in_tag | input | 4 | Descriptor identifier |
| bus_ready | input | 1 | Bus completes the access this cycle (low = wait state) |
| slot_valid | output | 4 | Occupancy: bit 0 fetch, 1 decode, 2 memory, 3 writeback |
| stall | output | 1 | Front of the pipeline is frozen this cycle |
| wb_tag | output | 4 | Tag of the retiring descriptor |
| wb_mem | output | 1 | Retiring descriptor is a memory operation |
| wb_dep | output | 1 | Dependency flag of the retiring descriptor |

## Verification
The checker assumes that reset is held high at start-up and that `bus_ready` is a defined level in every cycle. It also assumes that a source facing a low `in_ready` keeps its descriptor steady. The bench changes inputs only on falling edges. It holds the blocked descriptor unchanged for the whole wait sequence. It drives `bus_ready` low only when it means to test a wait state or to show that the signal is ignored with an empty or ALU-occupied memory slot.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  parameter int unsigned LSP_TAG_W = 4;
  parameter int unsigned LSP_NSLOT = 4;

  localparam int unsigned SL_FETCH = 0;
  localparam int unsigned SL_DEC   = 1;
  localparam int unsigned SL_MEM   = LSP_NSLOT - 2;
  localparam int unsigned SL_WB    = LSP_NSLOT - 1;

  typedef enum logic {
    OP_ALU = 1'b0,
    OP_MEM = 1'b1
  } op_e;

  typedef struct packed {
    op_e                  op;
    logic                 dep;
    logic [LSP_TAG_W-1:0] tag;
  } desc_t;
endpackage

// File: rtl/lsp_slot.sv
module lsp_slot
  import lsp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  hold,
  input  logic  src_vld,
  input  desc_t src_desc,
  output logic  vld,
  output desc_t desc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
    end else if (!hold) begin
      vld <= src_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (!hold) begin
      desc <= src_desc;
    end
  end
endmodule

// File: rtl/lsp_hazard.sv
module lsp_hazard
  import lsp_pkg::*;
(
  input  logic m_vld,
  input  op_e  m_op,
  input  logic bus_ready,
  output logic stall
);
  // A wait state only matters for a real memory access in the memory slot.
  always_comb begin
    stall = 1'b0;
    if (m_vld && (m_op == OP_MEM)) begin
      stall = !bus_ready;
    end
  end
endmodule

// File: rtl/lsp_pipe_ctrl.sv
module lsp_pipe_ctrl
  import lsp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_op,
  input  logic                 in_dep,
  input  logic [LSP_TAG_W-1:0] in_tag,
  input  logic                 bus_ready,
  output logic [LSP_NSLOT-1:0] slot_valid,
  output logic                 stall,
  output logic [LSP_TAG_W-1:0] wb_tag,
  output logic                 wb_mem,
  output logic                 wb_dep
);
  logic [LSP_NSLOT-1:0] v;
  desc_t                d [LSP_NSLOT];
  desc_t                in_desc;
  logic                 m_is_mem;

  always_comb begin
    in_desc.op  = in_op ? OP_MEM : OP_ALU;
    in_desc.dep = in_dep;
    in_desc.tag = in_tag;
  end

  assign m_is_mem = (d[SL_MEM].op == OP_MEM);

  lsp_hazard u_haz (
    .m_vld     (v[SL_MEM]),
    .m_op      (d[SL_MEM].op),
    .bus_ready (bus_ready),
    .stall     (stall)
  );

  for (genvar i = 0; i < LSP_NSLOT; i++) begin : g_slot
    localparam bit FROZEN = (i < LSP_NSLOT - 1);
    logic  src_v;
    desc_t src_d;
    if (i == 0) begin : g_head
      assign src_v = in_valid;
      assign src_d = in_desc;
    end else if (i == LSP_NSLOT - 1) begin : g_tail
      // writeback takes an empty slot while the memory slot is held
      assign src_v = v[i-1] & ~stall;
      assign src_d = d[i-1];
    end else begin : g_mid
      assign src_v = v[i-1];
      assign src_d = d[i-1];
    end
    lsp_slot u_slot (
      .clk      (clk),
      .rst      (rst),
      .hold     (stall & FROZEN),
      .src_vld  (src_v),
      .src_desc (src_d),
      .vld      (v[i]),
      .desc     (d[i])
    );
  end

  assign in_ready   = ~stall;
  assign slot_valid = v;
  assign wb_tag     = d[SL_WB].tag;
  assign wb_mem     = (d[SL_WB].op == OP_MEM);
  assign wb_dep     = d[SL_WB].dep;
endmodule

// File: rtl/lsp_pipe_ctrl_chk.sv
module lsp_pipe_ctrl_chk
  import lsp_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 stall,
  input logic                 in_ready,
  input logic                 m_mem,
  input logic [LSP_NSLOT-1:0] slot_valid
);
  AST_FRONT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    stall |=> slot_valid[SL_MEM:0] == $past(slot_valid[SL_MEM:0])); // R5

  AST_STALL_NEEDS_MEM: assert property (@(posedge clk) disable iff (rst)
    stall |-> (slot_valid[SL_MEM] && m_mem)); // R5

  AST_WB_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    stall |=> !slot_valid[SL_WB]); // R6

  AST_ALU_IGNORES_BUS: assert property (@(posedge clk) disable iff (rst)
    (slot_valid[SL_MEM] && !m_mem) |-> !stall); // R7

  AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    !stall |=> slot_valid[SL_WB] == $past(slot_valid[SL_MEM])); // R2

  AST_FETCH_KEPT: assert property (@(posedge clk) disable iff (rst)
    (slot_valid[SL_FETCH] && !in_ready) |=> slot_valid[SL_FETCH]); // R8
endmodule

bind lsp_pipe_ctrl lsp_pipe_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .stall      (stall),
  .in_ready   (in_ready),
  .m_mem      (m_is_mem),
  .slot_valid (slot_valid)
);

// File: tb/lsp_pipe_ctrl_test.sv
module lsp_pipe_ctrl_test;
  import lsp_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_op = 1'b0;
  logic       in_dep = 1'b0;
  logic [3:0] in_tag = '0;
  logic       bus_ready = 1'b1;
  logic [3:0] slot_valid;
  logic       stall;
  logic [3:0] wb_tag;
  logic       wb_mem;
  logic       wb_dep;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  lsp_pipe_ctrl uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dep(in_dep), .in_tag(in_tag), .bus_ready(bus_ready),
    .slot_valid(slot_valid), .stall(stall), .wb_tag(wb_tag),
    .wb_mem(wb_mem), .wb_dep(wb_dep)
  );

  // row: {iv, mem, dep, tag[3:0], br, slot[3:0], stall, wbtag[3:0], wbmem}
  function automatic logic [17:0] row(logic iv, logic mem, logic dep, logic [3:0] tag,
                                      logic br, logic [3:0] sl, logic st,
                                      logic [3:0] wt, logic wm);
    return {iv, mem, dep, tag, br, sl, st, wt, wm};
  endfunction

  localparam int NV = 18;
  localparam logic [17:0] VEC [NV] = '{
    row(1,1,0,4'd1,1, 4'b0000,0,4'd0,0),
    row(1,1,0,4'd2,1, 4'b0001,0,4'd0,0),
    row(1,0,1,4'd3,1, 4'b0011,0,4'd0,0),
    row(0,0,0,4'd0,1, 4'b0111,0,4'd0,0),
    row(0,0,0,4'd0,1, 4'b1110,0,4'd1,1),
    row(0,0,0,4'd0,0, 4'b1100,0,4'd2,1),
    row(0,0,0,4'd0,0, 4'b1000,0,4'd3,0),
    row(1,1,0,4'd4,1, 4'b0000,0,4'd0,0),
    row(1,1,0,4'd5,1, 4'b0001,0,4'd0,0),
    row(1,0,1,4'd6,1, 4'b0011,0,4'd0,0),
    row(1,0,0,4'd7,0, 4'b0111,1,4'd0,0),
    row(1,0,0,4'd7,0, 4'b0111,1,4'd0,0),
    row(1,0,0,4'd7,1, 4'b0111,0,4'd0,0),
    row(0,0,0,4'd0,1, 4'b1111,0,4'd4,1),
    row(0,0,0,4'd0,1, 4'b1110,0,4'd5,1),
    row(0,0,0,4'd0,0, 4'b1100,0,4'd6,0),
    row(0,0,0,4'd0,1, 4'b1000,0,4'd7,0),
    row(0,0,0,4'd0,1, 4'b0000,0,4'd0,0)
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #80000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset slots", int'(slot_valid), 0);
    chk("R1 reset stall", int'(stall), 0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {in_valid, in_op, in_dep, in_tag, bus_ready} = VEC[i][17:10];
      #1;
      chk($sformatf("R2 R3 R6 slots row %0d", i), int'(slot_valid), int'(VEC[i][9:6]));
      chk($sformatf("R5 R7 stall row %0d", i), int'(stall), int'(VEC[i][5]));
      chk($sformatf("R8 ready row %0d", i), int'(in_ready), int'(!VEC[i][5]));
      if (VEC[i][9]) begin
        chk($sformatf("R4 R9 wb tag row %0d", i), int'(wb_tag), int'(VEC[i][4:1]));
        chk($sformatf("R9 wb class row %0d", i), int'(wb_mem), int'(VEC[i][0]));
      end
      if (VEC[i][9] && VEC[i][4:1] == 4'd3)
        chk("R4 R9 dep flag retired", int'(wb_dep), 1);
    end

    // directed: reset in the middle of a wait state
    @(negedge clk);
    in_valid = 1'b1; in_op = 1'b1; in_dep = 1'b0; in_tag = 4'd9; bus_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk("R5 stall with waiting load", int'(stall), 1);
    chk("R5 load held in memory slot", int'(slot_valid), 4'b0100);
    @(negedge clk);
    #1;
    chk("R6 still held after second wait", int'(slot_valid), 4'b0100);
    rst = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 mid-run reset slots", int'(slot_valid), 0);
    chk("R1 mid-run reset stall", int'(stall), 0);
    rst = 1'b0;
    bus_ready = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule